// File: doc/BRIEF.md
# Destructive-Readout Word Memory Controller

This block holds a word-organised store in which sensing a word wipes it, and a controller that hides that behaviour from the host. Each access runs one fixed-length cycle with two phases. In the sense phase the addressed word is read out and the location is left at all zeros. In the restore phase a word is written back into that location. For a read, that word is the one just sensed, so the data survives. For a write, the sensed word is dropped and the new data is stored instead.

The host raises a request together with a write flag, an address and write data. The controller latches these on the edge where it accepts the request, then holds busy for the whole cycle and pulses done in its final clock. Requests seen while busy is high are dropped. A debug output marks the restore phase, which is the window in which the addressed location holds zero. The storage has no reset and no refresh: contents persist across controller resets and across any length of idle time.

Top module: `dro_mem_ctrl`

## Requirements
- R1: While rst_n is low and after it is released, busy, done and loc_cleared are 0 and rdata is 0. Stored words are not altered by reset.
- R2: A request is accepted on a rising edge where req is 1 and busy is 0. busy is then 1 for exactly SENSE_CYC+RESTORE_CYC clocks (12 by default), starting with the clock after that edge.
- R3: done is 1 for exactly one clock per accepted request: the last clock in which busy is 1.
- R4: After a read (we=1'b0), rdata shows the stored word from the clock after the sense phase ends (clock SENSE_CYC+1 of busy) onward. It stays unchanged until the sense phase of the next read. A write never changes rdata.
- R5: A read leaves the stored word unchanged, so back-to-back reads of one address return the same value.
- R6: loc_cleared is 1 exactly during the RESTORE_CYC restore clocks. In those clocks the addressed location holds zero.
- R7: After a write (we=1'b1) completes, the addressed location holds the write data.
- R8: addr, we and wdata are taken only on the accepting edge. Changes to them later in the cycle have no effect.
- R9: A request that arrives while busy is 1 is ignored. This includes a request during the done clock. Such a request changes no stored word and does not extend the cycle.
- R10: A location that is not accessed keeps its last value for any number of cycles. This includes a location whose neighbours are accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the controller only |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Data returned by the last read |
| busy | output | 1 | High while a cycle runs |
| done | output | 1 | One-clock pulse in the last clock of a cycle |
| loc_cleared | output | 1 | High during the restore phase, while the location is zero |

## Verification
The bench builds the block with DEPTH=64 and 16-bit words, keeping the default 6+6 phase split. With only 64 words, a full write sweep initialises every location, so every later read has a known expected value. The top address, 63, and address 0 both get directed accesses. The default phase lengths keep the 12-clock frame that the busy, done, flag and rdata checks are timed against. Noisy cycles change the host fields on every busy clock, including the done clock. Random reads then show whether any of those dropped requests touched the store.

// File: rtl/dro_pkg.sv
`timescale 1ns/1ps
package dro_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SENSE   = 2'd1,
    PH_RESTORE = 2'd2
  } dro_phase_e;

  // Width of a counter that must hold values 0 .. (max(a,b)-1).
  function automatic int unsigned phase_cnt_w(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > 2) ? $clog2(m) : 1;
  endfunction

endpackage

// File: rtl/dro_core_array.sv
`timescale 1ns/1ps
// Behavioural word store: clearing models the destructive sense,
// writing models the restore/inhibit pass. No reset: contents persist.
module dro_core_array #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2048,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              clr_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] word_out
);

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en)       cells[addr] <= wr_data;
    else if (clr_en) cells[addr] <= '0;
  end

  assign word_out = cells[addr];

endmodule

// File: rtl/dro_phase_seq.sv
`timescale 1ns/1ps
// Two-phase cycle sequencer: sense/clear phase then restore/write phase.
module dro_phase_seq
  import dro_pkg::*;
#(
  parameter int SENSE_CYC   = 6,
  parameter int RESTORE_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic sense_fire,
  output logic restore_fire,
  output logic in_gap
);

  localparam int CW = phase_cnt_w(SENSE_CYC, RESTORE_CYC);
  localparam logic [CW-1:0] LAST_S = CW'(SENSE_CYC - 1);
  localparam logic [CW-1:0] LAST_R = CW'(RESTORE_CYC - 1);

  dro_phase_e    phase_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          cnt_q <= '0;
          if (start) phase_q <= PH_SENSE;
        end
        PH_SENSE: begin
          if (cnt_q == LAST_S) begin
            phase_q <= PH_RESTORE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_RESTORE: begin
          if (cnt_q == LAST_R) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign busy         = (phase_q != PH_IDLE);
  assign sense_fire   = (phase_q == PH_SENSE)   && (cnt_q == LAST_S);
  assign restore_fire = (phase_q == PH_RESTORE) && (cnt_q == LAST_R);
  assign in_gap       = (phase_q == PH_RESTORE);

endmodule

// File: rtl/dro_mem_ctrl.sv
`timescale 1ns/1ps
module dro_mem_ctrl #(
  parameter int DATA_W      = 16,
  parameter int DEPTH       = 2048,
  parameter int ADDR_W      = $clog2(DEPTH),
  parameter int SENSE_CYC   = 6,
  parameter int RESTORE_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic              done,
  output logic              loc_cleared
);

  // Word written back in the restore phase.
  function automatic logic [DATA_W-1:0] pick_restore(
    input logic              is_wr,
    input logic [DATA_W-1:0] new_word,
    input logic [DATA_W-1:0] sensed_word
  );
    return is_wr ? new_word : sensed_word;
  endfunction

  // Named internal events (also observed by the bound checker).
  logic              start;
  logic              sense_fire;
  logic              restore_fire;
  logic [DATA_W-1:0] peek_word;
  logic [DATA_W-1:0] restore_word;

  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] sensed_q;
  logic [DATA_W-1:0] rdata_q;

  assign start = req && !busy;

  dro_phase_seq #(
    .SENSE_CYC  (SENSE_CYC),
    .RESTORE_CYC(RESTORE_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .sense_fire  (sense_fire),
    .restore_fire(restore_fire),
    .in_gap      (loc_cleared)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      sensed_q <= '0;
      rdata_q  <= '0;
    end else begin
      if (start) begin
        we_q    <= we;
        addr_q  <= addr;
        wdata_q <= wdata;
      end
      if (sense_fire) begin
        sensed_q <= peek_word;
        if (!we_q) rdata_q <= peek_word;
      end
    end
  end

  assign restore_word = pick_restore(we_q, wdata_q, sensed_q);

  dro_core_array #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W)
  ) u_array (
    .clk     (clk),
    .addr    (addr_q),
    .clr_en  (sense_fire),
    .wr_en   (restore_fire),
    .wr_data (restore_word),
    .word_out(peek_word)
  );

  assign rdata = rdata_q;
  assign done  = restore_fire;

endmodule

// File: rtl/dro_mem_ctrl_chk.sv
`timescale 1ns/1ps
module dro_mem_ctrl_chk #(
  parameter int DATA_W = 16,
  parameter int TOTAL  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              loc_cleared,
  input logic [DATA_W-1:0] rdata,
  input logic [DATA_W-1:0] peek_word,
  input logic [DATA_W-1:0] restore_word
);

  localparam int BW = $clog2(TOTAL + 2);

  logic [BW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == BW'(TOTAL)));

  p_done_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_done_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_gap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    loc_cleared |-> (peek_word == '0));

  p_gap_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    loc_cleared |-> busy);

  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(loc_cleared) |-> $stable(rdata));

  // R5 and R7: the restore pass lands the chosen word in the location.
  p_restore_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (peek_word == $past(restore_word)));

endmodule

bind dro_mem_ctrl dro_mem_ctrl_chk #(
  .DATA_W(DATA_W),
  .TOTAL (SENSE_CYC + RESTORE_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .loc_cleared (loc_cleared),
  .rdata       (rdata),
  .peek_word   (peek_word),
  .restore_word(restore_word)
);

// File: tb/dro_mem_ctrl_test.sv
`timescale 1ns/1ps
module dro_mem_ctrl_test;

  localparam int DW = 16;
  localparam int DP = 64;
  localparam int AW = 6;
  localparam int SP = 6;
  localparam int RP = 6;
  localparam int TOT = SP + RP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          busy, done, loc_cleared;

  int n_chk = 0;
  int n_fail = 0;

  logic [DW-1:0] shadow [DP];
  logic [DW-1:0] exp_rdata = '0;

  always #4 clk = ~clk;

  dro_mem_ctrl #(
    .DATA_W(DW), .DEPTH(DP), .SENSE_CYC(SP), .RESTORE_CYC(RP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busy(busy), .done(done),
    .loc_cleared(loc_cleared)
  );

  // Bench view of the word kept after an access.
  function automatic logic [DW-1:0] kept_word(input logic w, input logic [DW-1:0] nw,
                                              input logic [DW-1:0] old);
    if (w) return nw;
    return old;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One full access. noisy: host fields and req toggle on every busy clock.
  task automatic run_op(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit noisy);
    logic [DW-1:0] old_rd;
    logic [DW-1:0] new_rd;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(posedge clk);
    old_rd = exp_rdata;
    new_rd = w ? old_rd : shadow[a];
    shadow[a] = kept_word(w, d, shadow[a]);
    for (int k = 0; k < TOT; k++) begin
      @(negedge clk);
      if (noisy) begin
        req = 1'b1; we = 1'($urandom); addr = AW'($urandom); wdata = DW'($urandom);
      end else begin
        req = 1'b0;
      end
      chk(busy == 1'b1, "R2 busy during cycle", 32'(busy), 1);
      chk(done == (k == TOT - 1), "R3 done pulse", 32'(done), 32'(k == TOT - 1));
      chk(loc_cleared == (k >= SP), "R6 restore flag", 32'(loc_cleared), 32'(k >= SP));
      if (k < SP) chk(rdata == old_rd, "R4 rdata held", 32'(rdata), 32'(old_rd));
      else        chk(rdata == new_rd, "R4 rdata after sense", 32'(rdata), 32'(new_rd));
    end
    @(negedge clk);
    req = 1'b0;
    chk(busy == 1'b0, "R2 busy ends R9", 32'(busy), 0);
    chk(done == 1'b0, "R3 done single", 32'(done), 0);
    exp_rdata = new_rd;
  endtask

  task automatic check_idle_reset();
    chk(busy == 1'b0, "R1 busy", 32'(busy), 0);
    chk(done == 1'b0, "R1 done", 32'(done), 0);
    chk(loc_cleared == 1'b0, "R1 flag", 32'(loc_cleared), 0);
    chk(rdata == '0, "R1 rdata", 32'(rdata), 0);
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0D70));
    repeat (3) @(negedge clk);
    check_idle_reset();                              // R1
    rst_n = 1'b1;
    @(negedge clk);
    check_idle_reset();                              // R1 after release

    // Sweep: initialise every word (R7), address 63 included.
    for (int a = 0; a < DP; a++) run_op(1'b1, AW'(a), DW'($urandom), 1'b0);

    // Directed corners.
    run_op(1'b1, 6'd63, 16'hFFFF, 1'b0);             // R7 all ones, top address
    run_op(1'b0, 6'd63, 16'h0, 1'b0);                // R4 read
    run_op(1'b0, 6'd63, 16'h0, 1'b0);                // R5 second read restored
    run_op(1'b1, 6'd0, 16'h0000, 1'b0);              // R7 all zeros
    run_op(1'b0, 6'd0, 16'h0, 1'b0);                 // R5
    run_op(1'b1, 6'd5, 16'h1234, 1'b1);              // R8 R9 noisy write
    run_op(1'b0, 6'd5, 16'h0, 1'b1);                 // R8 R9 noisy read
    run_op(1'b0, 6'd5, 16'h0, 1'b0);                 // R5 after noisy read
    run_op(1'b0, 6'd4, 16'h0, 1'b0);                 // R10 neighbour kept
    run_op(1'b0, 6'd6, 16'h0, 1'b0);                 // R10 neighbour kept

    // Random mix: reads check the shadow, noise checks R9/R10.
    for (int i = 0; i < 220; i++)
      run_op(1'(($urandom % 3) == 0), AW'($urandom), DW'($urandom), ($urandom % 4) == 0);

    // Reset leaves the store alone (R1 R10).
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_idle_reset();
    rst_n = 1'b1;
    exp_rdata = '0;
    repeat (5) @(negedge clk);                       // R10 idle time
    run_op(1'b0, 6'd63, 16'h0, 1'b0);
    run_op(1'b0, 6'd0, 16'h0, 1'b0);
    run_op(1'b0, 6'd5, 16'h0, 1'b0);

    // Full read sweep: every location against the shadow (R5 R7 R9 R10).
    for (int a = 0; a < DP; a++) run_op(1'b0, AW'(a), 16'h0, 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule